// File: doc/BRIEF.md
# Multicycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a small load/store processor that finishes each instruction over several short clock cycles. One memory array holds both the program and the data. One ALU does every arithmetic and logic operation, including the program-counter increment and the branch-target sum. Holding registers between the steps carry partial results from one cycle to the next: instruction, memory data, two operands and the ALU result.

An external sequencer drives every multiplexer select and every write enable in each cycle. The datapath returns the opcode and function fields of the held instruction and the ALU zero flag, so the sequencer can pick its next state. A fill port and a peek port on the memory array let the surrounding system load a program and look at words without going through the datapath. The sequencer itself is not part of this block.

Top module: `mc_datapath`

## Requirements
- R1: While rst_n is low at a rising edge, the PC, instruction, memory-data, operand and ALU-result registers clear to zero. With iord low the memory address then reads 0, both decoded fields read 0 and the zero flag reads 1.
- R2: At each rising edge with ir_wr high, the instruction register loads the word at the current memory address. opcode shows its bits 31-26 and funct shows its bits 5-0.
- R3: With ir_wr low, the instruction register and both decoded fields keep their value, whatever the memory returns.
- R4: The A and B operand registers load, at every edge, the registers named by instruction bits 25-21 and 20-16. The ALU operation code is 0 for add, 1 for subtract, 2 for AND, 3 for OR and 4 for signed set-less-than, which gives 1 or 0.
- R5: src_a_sel picks the PC (0) or A (1). src_b_sel picks B (0), the constant 4 (1), the extended immediate (2) or the extended immediate shifted left two (3). With imm_sign low the 16-bit immediate is zero-extended.
- R6: With imm_sign high the immediate is sign-extended, so negative load offsets and backward branch offsets work.
- R7: When reg_wr is high, the write address is bits 15-11 when reg_dst is 1 and bits 20-16 when reg_dst is 0. The write data is the memory-data register when mem_to_reg is 1 and the ALU-result register when it is 0.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: The memory address is the ALU-result register when iord is 1 and the PC when iord is 0. Word index is address bits [AW+1:2]. Memory is written with B only at an edge where mem_wr is high.
- R10: The PC loads at an edge when pc_wr is high, or when pc_wr_cond is high and the zero flag is set. The new value is the live ALU result when pc_src is 0 and the ALU-result register when pc_src is 1.
- R11: zero is high exactly when the present ALU result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU-result register |
| mem_wr | input | 1 | Memory write enable |
| ir_wr | input | 1 | Instruction register load enable |
| reg_dst | input | 1 | Register write address: 0 bits 20-16, 1 bits 15-11 |
| mem_to_reg | input | 1 | Register write data: 0 ALU-result register, 1 memory-data register |
| reg_wr | input | 1 | Register file write enable |
| src_a_sel | input | 1 | ALU first operand: 0 PC, 1 A |
| src_b_sel | input | 2 | ALU second operand: B, 4, immediate, immediate shifted left two |
| imm_sign | input | 1 | Immediate extension: 0 zero, 1 sign |
| alu_op | input | 3 | ALU operation code |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when the zero flag is set |
| pc_src | input | 1 | Next PC: 0 live ALU result, 1 ALU-result register |
| fill_we | input | 1 | Fill-port write enable |
| fill_addr | input | MEM_AW | Fill-port word index |
| fill_data | input | DATA_W | Fill-port write data |
| peek_addr | input | MEM_AW | Peek-port word index |
| peek_data | output | DATA_W | Word at the peek index |
| mem_addr | output | DATA_W | Byte address presented to memory |
| opcode | output | 6 | Instruction bits 31-26 |
| funct | output | 6 | Instruction bits 5-0 |
| zero | output | 1 | ALU result is zero |

## Verification
The assertions assume the sequencer keeps mem_wr and fill_we apart from any cycle where the same word is also being read for a check. They also assume alu_op carries only the five defined codes. The bench acts as that sequencer: every instruction gets the classic fetch, decode, execute and write-back sequence with only the selects the step needs, and every other enable is held low. Memory is filled only while the datapath is idle. A bench-side register and memory model predicts the PC, the decoded fields, the branch zero flag and the stored words, and fixed constants back those predictions up.

// File: rtl/mcdp_pkg.sv
// Package: shared types and instruction field positions for the
// multicycle datapath. Assumes a 32-bit instruction word.
package mcdp_pkg;

    localparam int OPC_W   = 6;
    localparam int OPC_LSB = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG    = 2'd0,
        SRCB_FOUR   = 2'd1,
        SRCB_IMM    = 2'd2,
        SRCB_IMM_SH = 2'd3
    } srcb_e;

endpackage

// File: rtl/mcdp_alu.sv
// Module: mcdp_alu
// The single shared ALU. It is purely combinational: add, subtract,
// AND, OR and signed set-less-than. Unknown codes fall back to add.
// Assumes the operand width W is at least 2.
module mcdp_alu
    import mcdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         res_zero
);

    // Purpose: pick the result for the selected operation.
    always_comb begin
        case (op)
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = opa + opb;
        endcase
    end

    // Purpose: flag an all-zero result for the conditional PC write.
    always_comb begin
        res_zero = (res == '0);
    end

endmodule

// File: rtl/mcdp_imm_unit.sv
// Module: mcdp_imm_unit
// Widens the 16-bit immediate field to W bits, using zero or sign
// extension, and gives a copy shifted left two for word offsets.
// Assumes W > IW + 2.
module mcdp_imm_unit #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [IW-1:0] imm,
    input  logic          sign_en,
    output logic [W-1:0]  ext,
    output logic [W-1:0]  ext_sh
);

    localparam int PAD = W - IW;

    logic fill_bit;

    // Purpose: the padding bit is the immediate MSB only in sign mode.
    always_comb begin
        fill_bit = sign_en & imm[IW-1];
    end

    // Purpose: build the extended value and its word-offset form.
    always_comb begin
        ext    = {{PAD{fill_bit}}, imm};
        ext_sh = {ext[W-3:0], 2'b00};
    end

endmodule

// File: rtl/mcdp_regfile.sv
// Module: mcdp_regfile
// A register file with two asynchronous read ports and one synchronous
// write port. Entry 0 reads as zero and ignores writes. All entries
// clear under the synchronous active-low reset.
module mcdp_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);

    logic [W-1:0] regs [NREG];

    // Purpose: clear on reset, else write any entry except entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Purpose: read ports, with entry 0 forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
    end

endmodule

// File: rtl/mcdp_mem.sv
// Module: mcdp_mem
// Word-addressed memory shared by fetch and data access. The datapath
// port has an asynchronous read and a synchronous write, and is
// indexed by byte-address bits [AW+1:2]. A fill port writes by word
// index and wins over the datapath write. A peek port reads by word
// index. Contents are not reset.
module mcdp_mem #(
    parameter int W     = 32,
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [W-1:0]  fill_data,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);

    logic [W-1:0]  store [WORDS];
    logic [AW-1:0] word_idx;
    logic          unused_addr_bits;

    // Purpose: word index from the byte address; low and high bits unused.
    always_comb begin
        word_idx         = addr[AW+1:2];
        unused_addr_bits = ^{addr[W-1:AW+2], addr[1:0]};
    end

    // Purpose: one write per edge, fill port first.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            store[fill_addr] <= fill_data;
        end else if (we) begin
            store[word_idx] <= wdata;
        end
    end

    // Purpose: asynchronous read ports.
    always_comb begin
        rdata     = store[word_idx];
        peek_data = store[peek_addr];
    end

    // R9: a word being read stays put across an edge with no write.
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !fill_we) |=> ((word_idx != $past(word_idx)) || (rdata == $past(rdata))))
        else $error("p_mem_hold_r9");

endmodule

// File: rtl/mc_datapath.sv
// Module: mc_datapath
// Multicycle datapath with one memory and one ALU, both shared in
// time. IR, MDR, A, B and ALUOut hold values between steps. Every
// select and enable comes from an external sequencer. Assumes 32-bit
// instructions and NREG = 32, so register fields are five bits wide.
module mc_datapath
    import mcdp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NREG      = 32,
    parameter int MEM_WORDS = 256,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iord,
    input  logic                mem_wr,
    input  logic                ir_wr,
    input  logic                reg_dst,
    input  logic                mem_to_reg,
    input  logic                reg_wr,
    input  logic                src_a_sel,
    input  logic [1:0]          src_b_sel,
    input  logic                imm_sign,
    input  logic [2:0]          alu_op,
    input  logic                pc_wr,
    input  logic                pc_wr_cond,
    input  logic                pc_src,
    input  logic                fill_we,
    input  logic [MEM_AW-1:0]   fill_addr,
    input  logic [DATA_W-1:0]   fill_data,
    input  logic [MEM_AW-1:0]   peek_addr,
    output logic [DATA_W-1:0]   peek_data,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [OPC_W-1:0]    opcode,
    output logic [FN_W-1:0]     funct,
    output logic                zero
);

    localparam int RF_AW = $clog2(NREG);

    logic [DATA_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [DATA_W-1:0] mem_rdata, rd1, rd2;
    logic [DATA_W-1:0] src_a, src_b, alu_y;
    logic [DATA_W-1:0] imm_ext, imm_sh;
    logic [RF_AW-1:0]  rs_f, rt_f, rd_f, wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              pc_load;
    alu_op_e           op_e;
    logic              unused_shamt;

    // Purpose: split the held instruction into its fields.
    always_comb begin
        rs_f         = ir_q[RS_LSB +: RF_AW];
        rt_f         = ir_q[RT_LSB +: RF_AW];
        rd_f         = ir_q[RD_LSB +: RF_AW];
        opcode       = ir_q[OPC_LSB +: OPC_W];
        funct        = ir_q[FN_W-1:0];
        unused_shamt = ^ir_q[RD_LSB-1:FN_W];
        op_e         = alu_op_e'(alu_op);
    end

    // Purpose: memory address mux (instruction or data access).
    always_comb begin
        mem_addr = iord ? aluout_q : pc_q;
    end

    // Purpose: the two ALU operand muxes.
    always_comb begin
        src_a = src_a_sel ? a_q : pc_q;
        case (srcb_e'(src_b_sel))
            SRCB_REG:    src_b = b_q;
            SRCB_FOUR:   src_b = DATA_W'(4);
            SRCB_IMM:    src_b = imm_ext;
            default:     src_b = imm_sh;
        endcase
    end

    // Purpose: register write address and data selection.
    always_comb begin
        wr_addr = reg_dst ? rd_f : rt_f;
        wr_data = mem_to_reg ? mdr_q : aluout_q;
    end

    // Purpose: PC write condition, unconditional or on zero.
    always_comb begin
        pc_load = pc_wr | (pc_wr_cond & zero);
    end

    // Purpose: program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_load) begin
            pc_q <= pc_src ? aluout_q : alu_y;
        end
    end

    // Purpose: instruction register, loaded only on ir_wr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ir_wr) begin
            ir_q <= mem_rdata;
        end
    end

    // Purpose: step-to-step holding registers, loaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            mdr_q    <= mem_rdata;
            a_q      <= rd1;
            b_q      <= rd2;
            aluout_q <= alu_y;
        end
    end

    mcdp_imm_unit #(
        .W  (DATA_W),
        .IW (IMM_W)
    ) imm_i (
        .imm     (ir_q[IMM_W-1:0]),
        .sign_en (imm_sign),
        .ext     (imm_ext),
        .ext_sh  (imm_sh)
    );

    mcdp_alu #(
        .W (DATA_W)
    ) alu_i (
        .opa      (src_a),
        .opb      (src_b),
        .op       (op_e),
        .res      (alu_y),
        .res_zero (zero)
    );

    mcdp_regfile #(
        .W    (DATA_W),
        .NREG (NREG)
    ) rf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wr),
        .waddr (wr_addr),
        .wdata (wr_data),
        .ra1   (rs_f),
        .rd1   (rd1),
        .ra2   (rt_f),
        .rd2   (rd2)
    );

    mcdp_mem #(
        .W     (DATA_W),
        .WORDS (MEM_WORDS)
    ) mem_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (mem_addr),
        .we        (mem_wr),
        .wdata     (b_q),
        .rdata     (mem_rdata),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // R1: reset clears PC and IR.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0) && (ir_q == '0))
        else $error("p_reset_clear_r1");

    // R2: IR captures the memory word on ir_wr.
    p_ir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> (ir_q == $past(mem_rdata)))
        else $error("p_ir_load_r2");

    // R3: IR holds without ir_wr.
    p_ir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_wr |=> $stable(ir_q))
        else $error("p_ir_hold_r3");

    // R4: set-less-than yields only 0 or 1.
    p_slt_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == ALU_SLT) |-> (alu_y[DATA_W-1:1] == '0))
        else $error("p_slt_bool_r4");

    // R8: an rs field of 0 gives A = 0 one cycle later.
    p_r0_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_f == '0) |=> (a_q == '0))
        else $error("p_r0_reads_zero_r8");

    // R10: PC holds when neither write condition is met.
    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q))
        else $error("p_pc_hold_r10");

    // R10: a taken conditional write from the register copies ALUOut.
    p_pc_branch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_wr && pc_wr_cond && zero && pc_src) |=> (pc_q == $past(aluout_q)))
        else $error("p_pc_branch_r10");

endmodule

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
// Bench: acts as the sequencer. A driver runs a small program step by
// step and pushes expected observations into a scoreboard queue. A
// monitor pops and compares them at each falling edge.
module mc_datapath_tb_top;

    localparam int MW = 256;
    localparam int AW = 8;
    localparam logic [5:0] OP_R   = 6'h00;
    localparam logic [5:0] OP_ORI = 6'h21;
    localparam logic [5:0] OP_LW  = 6'h22;
    localparam logic [5:0] OP_SW  = 6'h23;
    localparam logic [5:0] OP_BEQ = 6'h24;
    localparam logic [5:0] F_ADD  = 6'h10;
    localparam logic [5:0] F_SUB  = 6'h11;
    localparam logic [5:0] F_AND  = 6'h12;
    localparam logic [5:0] F_OR   = 6'h13;
    localparam logic [5:0] F_SLT  = 6'h14;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, iord, mem_wr, ir_wr, reg_dst, mem_to_reg, reg_wr, src_a_sel;
    logic [1:0] src_b_sel;
    logic imm_sign, pc_wr, pc_wr_cond, pc_src, fill_we, zero;
    logic [2:0] alu_op;
    logic [AW-1:0] fill_addr, peek_addr;
    logic [31:0] fill_data, peek_data, mem_addr;
    logic [5:0] opcode, funct;

    mc_datapath #(.DATA_W(32), .NREG(32), .MEM_WORDS(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .iord(iord), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .imm_sign(imm_sign),
        .alu_op(alu_op), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
        .peek_addr(peek_addr), .peek_data(peek_data), .mem_addr(mem_addr),
        .opcode(opcode), .funct(funct), .zero(zero)
    );

    typedef struct {
        string       req;
        int          sel;
        int          addr;
        logic [31:0] exp;
    } item_t;

    item_t       sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] prog [22];
    logic [31:0] rf_m [32];
    logic [31:0] mem_m [MW];
    logic [31:0] pc_m;

    // sel: 0 mem_addr, 1 opcode, 2 funct, 3 zero, 4 peeked word
    task automatic push(input string req, input int sel, input int addr, input logic [31:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.addr = addr; it.exp = exp;
        sb.push_back(it);
    endtask

    // Monitor: compare queued expectations away from the rising edge.
    initial begin
        peek_addr = '0;
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                if (it.sel == 4) begin
                    peek_addr = it.addr[AW-1:0];
                    #0.1;
                end
                case (it.sel)
                    0:       act = mem_addr;
                    1:       act = {26'd0, opcode};
                    2:       act = {26'd0, funct};
                    3:       act = {31'd0, zero};
                    default: act = peek_data;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic ctl_idle();
        iord = 0; mem_wr = 0; ir_wr = 0; reg_dst = 0; mem_to_reg = 0; reg_wr = 0;
        src_a_sel = 0; src_b_sel = 2'd0; imm_sign = 0; alu_op = 3'd0;
        pc_wr = 0; pc_wr_cond = 0; pc_src = 0; fill_we = 0;
    endtask

    task automatic begin_cycle();
        @(negedge clk); #1;
        ctl_idle();
    endtask

    task automatic end_cycle();
        @(posedge clk); #1;
    endtask

    task automatic fill(input int idx, input logic [31:0] val);
        begin_cycle();
        fill_we = 1; fill_addr = idx[AW-1:0]; fill_data = val;
        end_cycle();
        mem_m[idx] = val;
    endtask

    function automatic logic [31:0] ii(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {OP_R, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    // R4 op codes: 0 add, 1 sub, 2 and, 3 or, 4 signed less-than.
    function automatic logic [2:0] fn_to_op(input logic [5:0] fn);
        case (fn)
            F_SUB:   return 3'd1;
            F_AND:   return 3'd2;
            F_OR:    return 3'd3;
            F_SLT:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd1:    return a - b;
            3'd2:    return a & b;
            3'd3:    return a | b;
            3'd4:    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return a + b;
        endcase
    endfunction

    // Run one instruction through fetch, decode and its own steps.
    task automatic run_one();
        logic [31:0] ins, sx, zx, ea, res, nxt;
        int rs, rt, rd;
        bit taken;
        ins = prog[pc_m >> 2];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'd0, ins[15:0]};
        // fetch: PC from the live ALU result (R2, R10)
        begin_cycle();
        ir_wr = 1; src_b_sel = 2'd1; pc_wr = 1;
        end_cycle();
        push("R2 fetch pc", 0, 0, pc_m + 4);
        push("R2 opcode", 1, 0, {26'd0, ins[31:26]});
        push("R2 funct", 2, 0, {26'd0, ins[5:0]});
        // decode: branch target into ALUOut, IR must hold (R3)
        begin_cycle();
        src_b_sel = 2'd3; imm_sign = 1;
        end_cycle();
        push("R3 ir hold", 1, 0, {26'd0, ins[31:26]});
        nxt = pc_m + 4;
        case (ins[31:26])
            OP_R: begin
                res = ref_alu(fn_to_op(ins[5:0]), rf_m[rs], rf_m[rt]);
                begin_cycle();
                src_a_sel = 1; src_b_sel = 2'd0; alu_op = fn_to_op(ins[5:0]);
                end_cycle();
                begin_cycle();
                reg_dst = 1; reg_wr = 1;
                end_cycle();
                if (rd != 0) rf_m[rd] = res;
            end
            OP_ORI: begin
                res = rf_m[rs] | zx;
                begin_cycle();
                src_a_sel = 1; src_b_sel = 2'd2; imm_sign = 0; alu_op = 3'd3;
                end_cycle();
                begin_cycle();
                reg_wr = 1;
                end_cycle();
                if (rt != 0) rf_m[rt] = res;
            end
            OP_LW, OP_SW: begin
                ea = rf_m[rs] + sx;
                begin_cycle();
                src_a_sel = 1; src_b_sel = 2'd2; imm_sign = 1;
                end_cycle();
                begin_cycle();
                iord = 1; mem_wr = (ins[31:26] == OP_SW);
                end_cycle();
                if (ins[31:26] == OP_SW) begin
                    mem_m[ea[AW+1:2]] = rf_m[rt];
                end else begin
                    begin_cycle();
                    mem_to_reg = 1; reg_wr = 1;
                    end_cycle();
                    if (rt != 0) rf_m[rt] = mem_m[ea[AW+1:2]];
                end
            end
            default: begin
                taken = (rf_m[rs] == rf_m[rt]);
                if (taken) nxt = pc_m + 4 + {sx[29:0], 2'b00};
                begin_cycle();
                src_a_sel = 1; src_b_sel = 2'd0; alu_op = 3'd1; pc_wr_cond = 1; pc_src = 1;
                end_cycle();
                push("R11 branch zero", 3, 0, {31'd0, taken});
                push("R10 branch pc", 0, 0, nxt);
            end
        endcase
        pc_m = nxt;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Driver
    initial begin
        ctl_idle();
        fill_addr = '0; fill_data = '0;
        rst_n = 0;
        for (int i = 0; i < 32; i++) rf_m[i] = 32'd0;
        for (int i = 0; i < MW; i++) mem_m[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1;
        push("R1 reset pc", 0, 0, 32'd0);
        push("R1 reset opcode", 1, 0, 32'd0);
        push("R1 reset funct", 2, 0, 32'd0);
        push("R1 reset zero", 3, 0, 32'd1);
        @(negedge clk); #1;
        rst_n = 1;

        prog[0]  = ii(OP_ORI, 0, 1, 16'h8001);
        prog[1]  = ii(OP_LW, 0, 2, 16'h0100);
        prog[2]  = rr(1, 2, 3, F_ADD);
        prog[3]  = ii(OP_SW, 0, 3, 16'h0104);
        prog[4]  = rr(1, 2, 4, F_SUB);
        prog[5]  = ii(OP_SW, 0, 4, 16'h0108);
        prog[6]  = rr(1, 2, 5, F_AND);
        prog[7]  = rr(2, 1, 6, F_SLT);
        prog[8]  = ii(OP_SW, 0, 5, 16'h010C);
        prog[9]  = ii(OP_SW, 0, 6, 16'h0110);
        prog[10] = ii(OP_ORI, 0, 8, 16'h0108);
        prog[11] = ii(OP_LW, 8, 7, 16'hFFFC);
        prog[12] = rr(7, 1, 9, F_OR);
        prog[13] = ii(OP_SW, 0, 9, 16'h0114);
        prog[14] = ii(OP_ORI, 0, 0, 16'h1234);
        prog[15] = ii(OP_SW, 0, 0, 16'h0118);
        prog[16] = ii(OP_SW, 0, 1, 16'h011C);
        prog[17] = ii(OP_BEQ, 1, 2, 16'd3);
        prog[18] = ii(OP_BEQ, 5, 6, 16'd2);
        prog[19] = 32'hFFFF_FFFF;
        prog[20] = 32'hFFFF_FFFF;
        prog[21] = ii(OP_BEQ, 0, 0, 16'hFFFD);
        for (int i = 0; i < 22; i++) fill(i, prog[i]);
        fill(64, 32'h8000_0003);
        fill(70, 32'hDEAD_BEEF);

        pc_m = 32'd0;
        for (int k = 0; k < 20; k++) run_one();

        begin_cycle();
        end_cycle();
        push("R9 load left word intact", 4, 64, 32'h8000_0003);
        push("R4 add result", 4, 65, 32'h8000_8004);
        push("R4 sub result", 4, 66, 32'h8000_7FFE);
        push("R4 and result", 4, 67, 32'h0000_0001);
        push("R4 slt signed", 4, 68, 32'h0000_0001);
        push("R6 neg offset load, R7 mdr path", 4, 69, 32'h8000_8005);
        push("R8 r0 ignores write", 4, 70, 32'h0000_0000);
        push("R5 zero extension", 4, 71, 32'h0000_8001);
        for (int i = 0; i < 22; i++) push("R9 program words kept", 4, i, mem_m[i]);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule